// File: doc/BRIEF.md
# Redistributor group power controller

This block sequences the shared power domain of several interrupt redistributor frames. Frames are gathered into groups, and each group sits in one switchable domain. Every frame exposes one 32-bit power word on a simple memory-mapped register port. Software sets or clears a per-frame power-down request in that word. The controller turns those requests into a level request/acknowledge handshake with an external power switch, one handshake per group. It reports the group's intended and achieved power state in the same word.

A group powers up as soon as any of its frames asks for power. It powers down only when the last frame that was on asks for off. Software treats the group as "in transit" while the intended-off bit and the achieved-off bit differ. It polls the frame's power-down bit until that bit matches the value it wrote. The switch may refuse a power-down. In that case the group returns to the on state and the domain never drops.

Top module: `rdist_grp_pwr_ctrl`

## Requirements
- R1: After reset every frame's power word reads 0x0000000D: request bit 0 = 1, gating bit 1 = 0, group-target-off bit 2 = 1, group-is-off bit 3 = 1. Every `sw_req` bit is 0.
- R2: The power word of frame f is at byte address f*2^SPAN_LOG2 + 0x24. A write to any other offset changes nothing, and a read of any other offset returns 0. Bits 31:4 read 0 and ignore writes.
- R3: Writing 0 to bit 0 of a frame whose group is off raises that group's `sw_req` one cycle after the write. Bit 2 then reads 0 and bit 3 reads 1, and bit 3 stays 1 until `sw_ack` is seen high. The group is on, with bit 3 = 0, on the clock after `sw_ack` is high.
- R4: A frame's bit 0 reads 1 if its stored request is off or its group is not fully on. It reads 0 only when the frame requests on and the group is on.
- R5: A group whose other frames are still on stays on when one frame requests off. When the last on frame requests off, the group drops `sw_req` and bit 2 reads 1 one cycle after that write.
- R6: A group powering down becomes off, with bit 3 = 1, on the clock after `sw_ack` is seen low.
- R7: While a group powers down, a high `grp_abort` returns it to on on the next clock. `sw_req` goes high again, bits 2 and 3 both read 0, and the group does not start another power-down until a frame makes a fresh on-to-off transition.
- R8: Writes to bit 0 while the group powers down are ignored, and the stored request keeps its old value.
- R9: A bit 0 write during power-up is held. The stored request keeps its old value until the group is on, then takes the held value one clock later. If that makes the last frame off, the group then powers down.
- R10: Bit 1 is a plain stored gating bit, writable at any time and read back unchanged. It has no effect on power sequencing.
- R11: Frame f belongs to group f / FRAMES_PER_GROUP. Activity in one group leaves the words and `sw_req` of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | IDX_W+SPAN_LOG2 | Byte address for read and write |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sw_req | output | NUM_GROUPS | Per-group request to power the domain on |
| sw_ack | input | NUM_GROUPS | Per-group switch state, 1 when the domain is on |
| grp_abort | input | NUM_GROUPS | Per-group refusal of a power-down in progress |

## Verification
The bench targets the corners where a group changes state. A controller that counted any single off request as "last" would drop `sw_req` while a sibling frame is still on. One that re-armed after an abort would loop straight back into power-down and never settle. A queued off request during power-up is checked one clock apart from its application: applying it at once would power the group down early, and dropping it would leave the group on for good. Writes during power-down, to the wrong offset, and into the upper bits are each followed by a read-back. A design that let any of them through would show a changed word.

// File: rtl/rgpc_pkg.sv
`timescale 1ns/1ps
package rgpc_pkg;
  typedef enum logic [1:0] {
    GS_OFF  = 2'd0,
    GS_UP   = 2'd1,
    GS_ON   = 2'd2,
    GS_DOWN = 2'd3
  } grp_state_e;

  localparam logic [7:0] PWR_WORD_OFS = 8'h24;

  // Group intends to be off (bit 2)
  function automatic logic grp_target_off(grp_state_e s);
    return (s == GS_OFF) || (s == GS_DOWN);
  endfunction

  // Group has not reached the on state (bit 3)
  function automatic logic grp_is_off(grp_state_e s);
    return (s == GS_OFF) || (s == GS_UP);
  endfunction

  function automatic logic [31:0] pack_word(logic req_off, logic gate,
                                            logic tgt_off, logic act_off);
    return {28'd0, act_off, tgt_off, gate, req_off};
  endfunction
endpackage

// File: rtl/rgpc_frame_slot.sv
`timescale 1ns/1ps
module rgpc_frame_slot
  import rgpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic       wr_pd,
  input  logic       wr_gate,
  input  grp_state_e grp_st,
  output logic       pd_req,
  output logic       gate,
  output logic       pend_vld
);
  logic pend_val;
  logic wr_direct, wr_queue, pend_apply;

  assign wr_direct  = wr_hit && ((grp_st == GS_OFF) || (grp_st == GS_ON));
  assign wr_queue   = wr_hit && (grp_st == GS_UP);
  assign pend_apply = pend_vld && (grp_st == GS_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_req   <= 1'b1;
      gate     <= 1'b0;
      pend_vld <= 1'b0;
      pend_val <= 1'b1;
    end else begin
      if (wr_hit) gate <= wr_gate;
      if (wr_direct) begin
        pd_req   <= wr_pd;
        pend_vld <= 1'b0;
      end else if (wr_queue) begin
        pend_vld <= 1'b1;
        pend_val <= wr_pd;
      end else if (pend_apply) begin
        pd_req   <= pend_val;
        pend_vld <= 1'b0;
      end
    end
  end

  // R8: a request write during power-down leaves the stored request alone
  a_r8_down_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && grp_st == GS_DOWN) |=> $stable(pd_req));

  // R9: a write during power-up does not reach the stored request at once
  a_r9_up_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && grp_st == GS_UP) |=> $stable(pd_req));
endmodule

// File: rtl/rgpc_group_seq.sv
`timescale 1ns/1ps
module rgpc_group_seq
  import rgpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       all_off,
  input  logic       any_pend,
  input  logic       sw_ack,
  input  logic       abort_req,
  output logic       sw_req,
  output grp_state_e st
);
  grp_state_e st_nxt;
  logic       all_off_q;
  logic       last_off_evt;

  // a fresh transition of the last on frame to off
  assign last_off_evt = all_off && !all_off_q && !any_pend;

  always_comb begin
    st_nxt = st;
    unique case (st)
      GS_OFF:  if (!all_off)     st_nxt = GS_UP;
      GS_UP:   if (sw_ack)       st_nxt = GS_ON;
      GS_ON:   if (last_off_evt) st_nxt = GS_DOWN;
      GS_DOWN: if (abort_req)    st_nxt = GS_ON;
               else if (!sw_ack) st_nxt = GS_OFF;
      default:                   st_nxt = GS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= GS_OFF;
      all_off_q <= 1'b1;
    end else begin
      st        <= st_nxt;
      all_off_q <= all_off;
    end
  end

  assign sw_req = (st == GS_UP) || (st == GS_ON);

  // R3: power-up holds until the switch acknowledges
  a_r3_up_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_UP && !sw_ack) |=> (st == GS_UP));

  // R6: power-down completes once the switch reports off
  a_r6_down_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_DOWN && !sw_ack && !abort_req) |=> (st == GS_OFF));

  // R7: an abort returns the group to on with the request raised
  a_r7_abort_to_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_DOWN && abort_req) |=> (st == GS_ON && sw_req));

  // R7: after an abort the group does not re-enter power-down by itself
  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_ON && all_off && $past(all_off)) |=> (st == GS_ON));
endmodule

// File: rtl/rdist_grp_pwr_ctrl.sv
`timescale 1ns/1ps
module rdist_grp_pwr_ctrl
  import rgpc_pkg::*;
#(
  parameter int NUM_GROUPS       = 2,
  parameter int FRAMES_PER_GROUP = 2,
  parameter int SPAN_LOG2        = 8,
  localparam int NUM_FRAMES      = NUM_GROUPS * FRAMES_PER_GROUP,
  localparam int IDX_W           = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int ADDR_W          = IDX_W + SPAN_LOG2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr_en,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic [NUM_GROUPS-1:0] sw_req,
  input  logic [NUM_GROUPS-1:0] sw_ack,
  input  logic [NUM_GROUPS-1:0] grp_abort
);
  logic [IDX_W-1:0]      frame_idx;
  logic                  ofs_match;
  logic                  reg_hit;
  logic [NUM_FRAMES-1:0] fr_pd, fr_gate, fr_pend;
  logic [NUM_GROUPS-1:0] grp_tgt, grp_off;
  grp_state_e            grp_st [NUM_GROUPS];

  assign frame_idx = reg_addr[ADDR_W-1:SPAN_LOG2];
  assign ofs_match = (reg_addr[SPAN_LOG2-1:0] == SPAN_LOG2'(PWR_WORD_OFS));
  assign reg_hit   = ofs_match && (int'(frame_idx) < NUM_FRAMES);

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    rgpc_frame_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (reg_wr_en && reg_hit && (int'(frame_idx) == f)),
      .wr_pd    (reg_wdata[0]),
      .wr_gate  (reg_wdata[1]),
      .grp_st   (grp_st[f / FRAMES_PER_GROUP]),
      .pd_req   (fr_pd[f]),
      .gate     (fr_gate[f]),
      .pend_vld (fr_pend[f])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    rgpc_group_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_off   (&fr_pd[g*FRAMES_PER_GROUP +: FRAMES_PER_GROUP]),
      .any_pend  (|fr_pend[g*FRAMES_PER_GROUP +: FRAMES_PER_GROUP]),
      .sw_ack    (sw_ack[g]),
      .abort_req (grp_abort[g]),
      .sw_req    (sw_req[g]),
      .st        (grp_st[g])
    );
    assign grp_tgt[g] = grp_target_off(grp_st[g]);
    assign grp_off[g] = grp_is_off(grp_st[g]);

    // R5: the group only heads off when every one of its frames requests off
    a_r5_last_frame_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_tgt[g]) |-> (&fr_pd[g*FRAMES_PER_GROUP +: FRAMES_PER_GROUP]));
  end

  always_comb begin
    reg_rdata = 32'd0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (reg_hit && (int'(frame_idx) == f)) begin
        reg_rdata = pack_word(fr_pd[f] | grp_off[f / FRAMES_PER_GROUP],
                              fr_gate[f],
                              grp_tgt[f / FRAMES_PER_GROUP],
                              grp_off[f / FRAMES_PER_GROUP]);
      end
    end
  end

  // R4: a frame never reads as on while its group is not on
  a_r4_frame_on_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && !reg_rdata[0]) |-> !reg_rdata[3]);
endmodule

// File: tb/rdist_grp_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module rdist_grp_pwr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  sw_req;
  logic [1:0]  sw_ack = 2'b00;
  logic [1:0]  grp_abort = 2'b00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rdist_grp_pwr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_req(sw_req),
    .sw_ack(sw_ack), .grp_abort(grp_abort)
  );

  // Word layout per the requirements: {act_off, tgt_off, gate, req_read}
  function automatic logic [31:0] word(bit req_rd, bit gate, bit tgt, bit act);
    logic [31:0] w = 32'd0;
    w[0] = req_rd; w[1] = gate; w[2] = tgt; w[3] = act;
    return w;
  endfunction

  function automatic logic [9:0] faddr(int f, int ofs);
    return 10'(f * 256 + ofs);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(int f, int ofs, logic [31:0] d);
    @(negedge clk);
    reg_addr = faddr(f, ofs); reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int f, int ofs, logic [31:0] exp);
    reg_addr = faddr(f, ofs);
    #0.5;
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int f = 0; f < 4; f++) rd_chk("R1 reset word", f, 'h24, word(1, 0, 1, 1));
    chk("R1 reset sw_req", 32'(sw_req), 32'd0);
    rd_chk("R2 other offset reads 0", 0, 'h20, 32'd0);
  endtask

  task automatic t_power_up;
    wr(0, 'h24, 32'hFFFF_FFF0);
    chk("R3 no request in write cycle", 32'(sw_req[0]), 32'd0);
    idle(1);
    chk("R3 sw_req raised", 32'(sw_req[0]), 32'd1);
    rd_chk("R3 in transit", 0, 'h24, word(1, 0, 0, 1));
    idle(3);
    rd_chk("R3 waits for ack", 0, 'h24, word(1, 0, 0, 1));
    rd_chk("R11 other group untouched", 2, 'h24, word(1, 0, 1, 1));
    sw_ack[0] = 1'b1;
    idle(1);
    rd_chk("R3 R2 on, upper bits zero", 0, 'h24, word(0, 0, 0, 0));
    rd_chk("R4 off frame in on group", 1, 'h24, word(1, 0, 0, 0));
    chk("R11 other sw_req", 32'(sw_req[1]), 32'd0);
  endtask

  task automatic t_last_off;
    wr(1, 'h24, 32'h0);
    rd_chk("R4 second frame on", 1, 'h24, word(0, 0, 0, 0));
    wr(0, 'h24, 32'h1);
    idle(2);
    rd_chk("R5 not last, group stays on", 0, 'h24, word(1, 0, 0, 0));
    chk("R5 sw_req held", 32'(sw_req[0]), 32'd1);
    wr(1, 'h24, 32'h1);
    idle(1);
    chk("R5 sw_req dropped", 32'(sw_req[0]), 32'd0);
    rd_chk("R5 target off", 1, 'h24, word(1, 0, 1, 0));
    wr(0, 'h24, 32'h0);
    idle(1);
    rd_chk("R8 write ignored in down", 0, 'h24, word(1, 0, 1, 0));
    sw_ack[0] = 1'b0;
    idle(1);
    rd_chk("R6 group off", 0, 'h24, word(1, 0, 1, 1));
    rd_chk("R8 stored request still off", 1, 'h24, word(1, 0, 1, 1));
    chk("R6 R8 stays off", 32'(sw_req[0]), 32'd0);
  endtask

  task automatic t_abort;
    wr(2, 'h24, 32'h0);
    idle(1);
    sw_ack[1] = 1'b1;
    idle(1);
    rd_chk("R3 group1 on", 2, 'h24, word(0, 0, 0, 0));
    wr(2, 'h24, 32'h1);
    idle(1);
    rd_chk("R5 group1 going down", 2, 'h24, word(1, 0, 1, 0));
    grp_abort[1] = 1'b1;
    idle(1);
    grp_abort[1] = 1'b0;
    rd_chk("R7 back on after abort", 2, 'h24, word(1, 0, 0, 0));
    chk("R7 sw_req again", 32'(sw_req[1]), 32'd1);
    idle(4);
    rd_chk("R7 no re-entry", 2, 'h24, word(1, 0, 0, 0));
    wr(2, 'h20, 32'hFFFF_FFFC);
    rd_chk("R2 wrong offset no effect", 2, 'h24, word(1, 0, 0, 0));
  endtask

  task automatic t_queue;
    wr(0, 'h24, 32'h0);
    idle(1);
    wr(0, 'h24, 32'h1);
    rd_chk("R9 up in progress", 0, 'h24, word(1, 0, 0, 1));
    sw_ack[0] = 1'b1;
    idle(1);
    rd_chk("R9 held request not yet applied", 0, 'h24, word(0, 0, 0, 0));
    idle(1);
    rd_chk("R9 held request applied", 0, 'h24, word(1, 0, 0, 0));
    idle(1);
    rd_chk("R9 then powers down", 0, 'h24, word(1, 0, 1, 0));
    chk("R9 sw_req dropped", 32'(sw_req[0]), 32'd0);
    sw_ack[0] = 1'b0;
    idle(1);
    rd_chk("R6 off again", 0, 'h24, word(1, 0, 1, 1));
  endtask

  task automatic t_gate;
    wr(3, 'h24, 32'h3);
    rd_chk("R10 gate set", 3, 'h24, word(1, 1, 0, 0));
    idle(2);
    chk("R10 no effect on power", 32'(sw_req[1]), 32'd1);
    rd_chk("R10 R11 neighbour frame", 2, 'h24, word(1, 0, 0, 0));
    wr(3, 'h24, 32'h1);
    rd_chk("R10 gate cleared", 3, 'h24, word(1, 0, 0, 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_power_up();
    t_last_off();
    t_abort();
    t_queue();
    t_gate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule